// File: doc/BRIEF.md
# Sprite-Table Block Copy Engine

This block fills the sprite attribute memory with one fixed-size block of bytes, started by a single CPU register write. The byte the CPU writes to the start register names a 256-byte source page. The engine then reads 160 consecutive bytes from the start of that page and writes them to consecutive addresses starting at 0xFE00. It drives these accesses on a simple synchronous memory bus of its own.

The transfer always lasts a fixed budget of 640 clocks, which is 160 bytes at 4 clocks each. A flag stays high for the whole budget, and an arbiter elsewhere may use it to keep the CPU off the bus. A second output combines this flag with the busy flag of another DMA engine. A new start write during a running copy discards the copy and begins a fresh one from the new page.

Top module: `spr_dma_engine`

## Requirements
- R1: After reset the active flag is low, neither memory strobe is asserted, and `any_dma_active` equals `ext_dma_active`.
- R2: A clock edge that samples `cpu_wr_en` high with `cpu_addr` equal to 0xFF46 starts a transfer. `dma_active` is high for exactly the 640 cycles that follow that edge and low in the 641st.
- R3: The byte written at the start is kept as the source page. Byte i (i = 0..159) is read from address {page, i}, so the source is always page-aligned.
- R4: Byte i is written to address 0xFE00 + i. The writes run in ascending order, one per byte, so 160 writes cover 0xFE00..0xFE9F.
- R5: Memory read data is valid in the cycle after the read strobe. The byte written for index i equals the byte the memory returned for the read of source byte i.
- R6: Counting cycles from 0 after the start edge, the read strobe for byte i is high only in cycle 4i and the write strobe only in cycle 4i+2. The two strobes are never high together.
- R7: A start write while a transfer is running reloads the page and restarts the copy at i = 0 in the next cycle. The active flag then stays high for a full 640 cycles from that edge.
- R8: A CPU write to any address other than 0xFF46 has no effect on the active flag, the strobes, the addresses or the data of a transfer, whether the engine is idle or running.
- R9: `any_dma_active` is the OR of `dma_active` and `ext_dma_active` in every cycle.
- R10: While `dma_active` is low, neither memory strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr_en | input | 1 | CPU register write enable |
| cpu_addr | input | 16 | CPU register write address |
| cpu_wdata | input | 8 | CPU register write data (source page) |
| mem_addr | output | 16 | Memory bus address |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read data, valid the cycle after `mem_rd` |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| dma_active | output | 1 | This engine's transfer is running |
| ext_dma_active | input | 1 | Busy flag of another DMA engine |
| any_dma_active | output | 1 | Either engine busy |

## Verification
The bench restarts transfers at the first cycle, at the very last cycle and at random points in between. A design that failed to clear the byte index or the phase would then write the old page's bytes or write to the wrong offsets, and a design that did not reload the budget would drop the active flag early. Each full run is checked cycle by cycle against the 4-clock read, capture and write pattern and against the exact 640-cycle length of the flag. An off-by-one counter shows up there as a flag that falls one cycle early or late, or as a strobe in the wrong slot. The bench also writes to neighbouring register addresses, both while idle and during a copy, and injects random values on the other engine's flag. A decoder that matched too few address bits would start a spurious transfer, and a broken OR would show up on the combined flag.

// File: rtl/spr_dma_pkg.sv
package spr_dma_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int PAGE_W = 8;

    // Operation carried out in one slot of a byte's clock group
    typedef enum logic [1:0] {
        OP_READ    = 2'd0,
        OP_CAPTURE = 2'd1,
        OP_WRITE   = 2'd2,
        OP_IDLE    = 2'd3
    } slot_op_e;

    // One cycle of memory bus request
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              rd;
        logic              wr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    // Slot 0 reads, slot 1 captures the returned data, slot 2 writes
    function automatic slot_op_e slot_op(input int unsigned slot);
        case (slot)
            0:       return OP_READ;
            1:       return OP_CAPTURE;
            2:       return OP_WRITE;
            default: return OP_IDLE;
        endcase
    endfunction

    // Page-aligned source address for a byte offset
    function automatic logic [ADDR_W-1:0] src_address(
        input logic [PAGE_W-1:0] page,
        input logic [ADDR_W-1:0] offset
    );
        return {page, {(ADDR_W-PAGE_W){1'b0}}} + offset;
    endfunction

endpackage

// File: rtl/spr_dma_start_reg.sv
module spr_dma_start_reg
    import spr_dma_pkg::*;
#(
    parameter logic [ADDR_W-1:0] START_ADDR = 16'hFF46
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_wr_en,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              start,
    output logic [PAGE_W-1:0] page_q
);

    assign start = cpu_wr_en && (cpu_addr == START_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
        end else if (start) begin
            page_q <= cpu_wdata[PAGE_W-1:0];
        end
    end

endmodule

// File: rtl/spr_dma_budget.sv
module spr_dma_budget #(
    parameter int BUDGET = 640
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic active
);

    localparam int CNT_W = $clog2(BUDGET + 1);

    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= CNT_W'(BUDGET);
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign active = (remain_q != '0);

endmodule

// File: rtl/spr_dma_seq.sv
module spr_dma_seq
    import spr_dma_pkg::*;
#(
    parameter int                XFER_BYTES    = 160,
    parameter int                CLKS_PER_BYTE = 4,
    parameter logic [ADDR_W-1:0] DEST_BASE     = 16'hFE00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              active,
    input  logic [PAGE_W-1:0] page,
    input  logic [DATA_W-1:0] mem_rdata,
    output bus_req_t          req
);

    localparam int SLOT_W = (CLKS_PER_BYTE > 1) ? $clog2(CLKS_PER_BYTE) : 1;
    localparam int IDX_W  = $clog2(XFER_BYTES + 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(CLKS_PER_BYTE - 1);

    logic [SLOT_W-1:0] slot_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] hold_q;
    slot_op_e          op;
    logic [ADDR_W-1:0] offset;

    assign op     = slot_op(int'(slot_q));
    assign offset = ADDR_W'(idx_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
            idx_q  <= '0;
        end else if (restart) begin
            slot_q <= '0;
            idx_q  <= '0;
        end else if (active) begin
            if (slot_q == LAST_SLOT) begin
                slot_q <= '0;
                idx_q  <= idx_q + 1'b1;
            end else begin
                slot_q <= slot_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (active && !restart && op == OP_CAPTURE) begin
            hold_q <= mem_rdata;
        end
    end

    always_comb begin
        req       = '0;
        req.rd    = active && (op == OP_READ);
        req.wr    = active && (op == OP_WRITE);
        req.wdata = hold_q;
        if (op == OP_READ) begin
            req.addr = src_address(page, offset);
        end else begin
            req.addr = DEST_BASE + offset;
        end
    end

endmodule

// File: rtl/spr_dma_engine.sv
module spr_dma_engine
    import spr_dma_pkg::*;
#(
    parameter logic [15:0] START_ADDR    = 16'hFF46,
    parameter logic [15:0] DEST_BASE     = 16'hFE00,
    parameter int          XFER_BYTES    = 160,
    parameter int          CLKS_PER_BYTE = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_wr_en,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_wdata,
    output logic [15:0] mem_addr,
    output logic        mem_rd,
    input  logic [7:0]  mem_rdata,
    output logic        mem_wr,
    output logic [7:0]  mem_wdata,
    output logic        dma_active,
    input  logic        ext_dma_active,
    output logic        any_dma_active
);

    localparam int BUDGET = XFER_BYTES * CLKS_PER_BYTE;

    logic              start;
    logic [PAGE_W-1:0] page_q;
    logic              active;
    bus_req_t          req;

    spr_dma_start_reg #(
        .START_ADDR(START_ADDR)
    ) u_start (
        .clk      (clk),
        .rst      (rst),
        .cpu_wr_en(cpu_wr_en),
        .cpu_addr (cpu_addr),
        .cpu_wdata(cpu_wdata),
        .start    (start),
        .page_q   (page_q)
    );

    spr_dma_budget #(
        .BUDGET(BUDGET)
    ) u_budget (
        .clk   (clk),
        .rst   (rst),
        .load  (start),
        .active(active)
    );

    spr_dma_seq #(
        .XFER_BYTES   (XFER_BYTES),
        .CLKS_PER_BYTE(CLKS_PER_BYTE),
        .DEST_BASE    (DEST_BASE)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .restart  (start),
        .active   (active),
        .page     (page_q),
        .mem_rdata(mem_rdata),
        .req      (req)
    );

    assign mem_addr       = req.addr;
    assign mem_rd         = req.rd;
    assign mem_wr         = req.wr;
    assign mem_wdata      = req.wdata;
    assign dma_active     = active;
    assign any_dma_active = active | ext_dma_active;

endmodule

// File: rtl/spr_dma_checker.sv
module spr_dma_checker #(
    parameter logic [15:0] START_ADDR = 16'hFF46,
    parameter logic [15:0] DEST_BASE  = 16'hFE00,
    parameter int          XFER_BYTES = 160,
    parameter int          BUDGET     = 640
) (
    input logic        clk,
    input logic        rst,
    input logic        cpu_wr_en,
    input logic [15:0] cpu_addr,
    input logic [15:0] mem_addr,
    input logic        mem_rd,
    input logic [7:0]  mem_rdata,
    input logic        mem_wr,
    input logic [7:0]  mem_wdata,
    input logic        dma_active,
    input logic        ext_dma_active,
    input logic        any_dma_active
);

    localparam int RUN_W = $clog2(BUDGET + 2);

    logic             go;
    logic [RUN_W-1:0] run_len;

    assign go = cpu_wr_en && (cpu_addr == START_ADDR);

    // Cycles with the flag high since the last start edge
    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
        end else if (go) begin
            run_len <= '0;
        end else if (dma_active) begin
            run_len <= run_len + 1'b1;
        end
    end

    p_start_sets_active_r2: assert property (@(posedge clk) disable iff (rst)
        go |=> dma_active);

    p_budget_length_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(dma_active) |-> (run_len == RUN_W'(BUDGET)));

    p_src_in_page_r3: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (mem_addr[7:0] < 8'(XFER_BYTES)));

    p_dest_window_r4: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (mem_addr >= DEST_BASE && mem_addr < DEST_BASE + 16'(XFER_BYTES)));

    p_data_forward_r5: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (mem_wdata == $past(mem_rdata)));

    p_write_after_read_r6: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> $past(mem_rd, 2));

    p_strobes_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    p_other_engine_r9: assert property (@(posedge clk) disable iff (rst)
        (ext_dma_active || dma_active) |-> any_dma_active);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !dma_active |-> (!mem_rd && !mem_wr));

endmodule

bind spr_dma_engine spr_dma_checker #(
    .START_ADDR(START_ADDR),
    .DEST_BASE (DEST_BASE),
    .XFER_BYTES(XFER_BYTES),
    .BUDGET    (XFER_BYTES * CLKS_PER_BYTE)
) u_spr_dma_checker (
    .clk           (clk),
    .rst           (rst),
    .cpu_wr_en     (cpu_wr_en),
    .cpu_addr      (cpu_addr),
    .mem_addr      (mem_addr),
    .mem_rd        (mem_rd),
    .mem_rdata     (mem_rdata),
    .mem_wr        (mem_wr),
    .mem_wdata     (mem_wdata),
    .dma_active    (dma_active),
    .ext_dma_active(ext_dma_active),
    .any_dma_active(any_dma_active)
);

// File: tb/test_spr_dma_engine.sv
module test_spr_dma_engine;

    localparam int CLK_PERIOD = 10;
    localparam int BYTES      = 160;
    localparam int CPB        = 4;
    localparam int BUDGET     = BYTES * CPB;
    localparam logic [15:0] START = 16'hFF46;
    localparam logic [15:0] DEST  = 16'hFE00;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_wr_en = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_wdata = 8'h00;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_rdata = 8'h00;
    logic        mem_wr;
    logic [7:0]  mem_wdata;
    logic        dma_active;
    logic        ext_dma_active = 1'b0;
    logic        any_dma_active;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    spr_dma_engine i_spr_dma_engine (
        .clk           (clk),
        .rst           (rst),
        .cpu_wr_en     (cpu_wr_en),
        .cpu_addr      (cpu_addr),
        .cpu_wdata     (cpu_wdata),
        .mem_addr      (mem_addr),
        .mem_rd        (mem_rd),
        .mem_rdata     (mem_rdata),
        .mem_wr        (mem_wr),
        .mem_wdata     (mem_wdata),
        .dma_active    (dma_active),
        .ext_dma_active(ext_dma_active),
        .any_dma_active(any_dma_active)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory content as a function of address
    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[15:8] ^ {a[6:0], a[7]} ^ 8'h5A;
    endfunction

    // Synchronous memory: data valid the cycle after the read strobe
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem_byte(mem_addr);
    end

    function automatic logic [15:0] other_addr();
        logic [15:0] a;
        a = 16'hFF40 + 16'($urandom % 16);
        if (a == START) a = 16'hFF47;
        return a;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Starts a transfer of page pg and checks ncyc cycles of it.
    // inj >= 0 injects a write to another register in that cycle.
    task automatic run_xfer(input logic [7:0] pg, input int ncyc, input int inj,
                            input string tag);
        int e_act = 0, e_str = 0, e_src = 0, e_dst = 0, e_any = 0;
        cpu_addr  = START;
        cpu_wdata = pg;
        cpu_wr_en = 1'b1;
        @(negedge clk);
        cpu_wr_en = 1'b0;
        for (int k = 0; k < ncyc; k++) begin
            bit rdx, wrx;
            int i;
            rdx = (k % CPB == 0);
            wrx = (k % CPB == 2);
            i   = k / CPB;
            if (dma_active !== 1'b1) e_act++;
            if (any_dma_active !== 1'b1) e_any++;
            if (mem_rd !== rdx || mem_wr !== wrx) e_str++;
            if (rdx && mem_addr !== {pg, 8'(i)}) e_src++;
            if (wrx && (mem_addr !== DEST + 16'(i) ||
                        mem_wdata !== mem_byte({pg, 8'(i)}))) e_dst++;
            if (k == inj) begin
                cpu_addr  = other_addr();
                cpu_wdata = 8'($urandom);
                cpu_wr_en = 1'b1;
            end else begin
                cpu_wr_en = 1'b0;
            end
            ext_dma_active = 1'($urandom % 2);
            @(negedge clk);
        end
        cpu_wr_en = 1'b0;
        check(e_act == 0, "R2", {tag, " active during budget"}, e_act, 0);
        check(e_str == 0, "R6", {tag, " strobe slots"}, e_str, 0);
        check(e_src == 0, "R3", {tag, " source addresses"}, e_src, 0);
        check(e_dst == 0, "R4", {tag, " dest address and R5 data"}, e_dst, 0);
        check(e_any == 0, "R9", {tag, " combined flag while running"}, e_any, 0);
        if (inj >= 0)
            check(e_act + e_str + e_src + e_dst == 0, "R8",
                  {tag, " other-register write during run"},
                  e_act + e_str + e_src + e_dst, 0);
    endtask

    // Called at cycle BUDGET after a start: flag must now be low
    task automatic check_end(input string tag);
        check(dma_active === 1'b0, "R2", {tag, " flag low after budget"},
              int'(dma_active), 0);
        check(!mem_rd && !mem_wr, "R10", {tag, " quiet after budget"},
              int'(mem_rd) + int'(mem_wr), 0);
    endtask

    task automatic idle_cycles(input int n, input bit poke, input string tag);
        int e = 0, e_any = 0;
        for (int k = 0; k < n; k++) begin
            if (dma_active !== 1'b0 || mem_rd !== 1'b0 || mem_wr !== 1'b0) e++;
            if (any_dma_active !== ext_dma_active) e_any++;
            if (poke && (k % 2 == 0)) begin
                cpu_addr  = other_addr();
                cpu_wdata = 8'($urandom);
                cpu_wr_en = 1'b1;
            end else begin
                cpu_wr_en = 1'b0;
            end
            ext_dma_active = 1'($urandom % 2);
            @(negedge clk);
        end
        cpu_wr_en = 1'b0;
        check(e == 0, poke ? "R8" : "R10", {tag, " idle quiet"}, e, 0);
        check(e_any == 0, "R9", {tag, " combined flag idle"}, e_any, 0);
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240225));
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state while held in reset
        check(dma_active === 1'b0 && !mem_rd && !mem_wr, "R1", "reset outputs",
              int'(dma_active) + int'(mem_rd) + int'(mem_wr), 0);
        ext_dma_active = 1'b1;
        #1;
        check(any_dma_active === 1'b1, "R1", "combined flag in reset",
              int'(any_dma_active), 1);
        @(negedge clk);
        rst = 1'b0;
        ext_dma_active = 1'b0;
        #1;
        check(any_dma_active === 1'b0, "R1", "combined flag after reset",
              int'(any_dma_active), 0);
        @(negedge clk);

        // R8: other registers written while idle
        idle_cycles(12, 1'b1, "idle pokes");

        // Directed full copies, page extremes
        run_xfer(8'hC0, BUDGET, -1, "page C0");
        check_end("page C0");
        idle_cycles(5, 1'b0, "after C0");
        run_xfer(8'h00, BUDGET, 2, "page 00");
        check_end("page 00");
        run_xfer(8'hFF, BUDGET, 637, "page FF");
        check_end("page FF");

        // R7: restart in the first cycle, last cycle, and random points
        run_xfer(8'h12, 1, -1, "pre-restart first");
        run_xfer(8'h34, BUDGET, -1, "R7 restart at cycle 1");
        check_end("R7 restart at cycle 1");
        run_xfer(8'h56, BUDGET - 1, -1, "pre-restart last");
        run_xfer(8'h78, BUDGET, -1, "R7 restart at last cycle");
        check_end("R7 restart at last cycle");
        for (int r = 0; r < 4; r++) begin
            int n;
            n = 1 + int'($urandom % (BUDGET - 1));
            run_xfer(8'($urandom), n, -1, "pre-restart random");
            run_xfer(8'($urandom), BUDGET, int'($urandom % BUDGET),
                     "R7 restart random");
            check_end("R7 restart random");
            idle_cycles(int'($urandom % 6) + 1, 1'b1, "between runs");
        end

        // Back-to-back start right at completion
        run_xfer(8'hA5, BUDGET, -1, "page A5");
        run_xfer(8'h5A, BUDGET, -1, "page 5A back to back");
        check_end("page 5A back to back");

        finish_run();
    end

endmodule